// File: doc/BRIEF.md
# Morton swizzled texture address generator

This block produces the address pairs needed to copy a linear, power-of-two sized image into a surface stored in Z-order. For each sub-tile of the image it gives one source address in linear layout and one destination address in swizzled layout. The destination index is built by interleaving the coordinate bits: x goes to the even bit positions and y to the odd ones. That index is then scaled by the pixel size. Images wider or taller than 1024 pixels are split into sub-tiles of at most 1024 by 1024. Columns are visited in the inner loop and rows in the outer loop.

A single start command can walk a whole mipmap chain. After each level, both base offsets move forward by the byte size of that level. Width, height and source pitch are then each halved. Each address pair also carries a surface descriptor: the log2 of the current level's width and height as two separate fields, plus the sub-tile size. Pairs leave on a valid/ready handshake at one pair per cycle. A done pulse marks the end of the chain, and an error pulse marks a start whose size is rejected. The block moves no pixel data.

Top module: `morton_addr_gen`

## Requirements
- R1: The destination address of a sub-tile at (cx, cy) is `dst_base_of_level + M(cx, cy) * bpp`. In M, bit i of cx lands at bit 2i and bit i of cy lands at bit 2i+1, for i from 0 to 11.
- R2: The source address of that sub-tile is `src_base_of_level + cy * pitch_of_level + cx * bpp`, computed modulo 2^32.
- R3: The sub-tile width is min(width, 1024) and the sub-tile height is min(height, 1024). Sub-tiles are emitted with cx stepping in the inner loop and cy in the outer loop, both starting at 0.
- R4: When a level ends, both bases advance by width*height*bpp, and width, height and pitch are each shifted right by one. `out_level` counts levels from 0.
- R5: Each pair carries `out_log2_w` = log2(level width) and `out_log2_h` = log2(level height).
- R6: A start in idle whose width or height is zero or not a power of two makes `err` high for exactly one cycle, on the cycle after the start edge. That start produces no valid pair and no done.
- R7: While `out_valid` is high and `out_ready` is low, every output field holds its value and `out_valid` stays high.
- R8: `done` is high for one cycle, right after the edge that accepts the final pair. A good start with `levels` = 0 emits no pair and raises `done` on the cycle after the start edge.
- R9: The chain ends early, after the level whose halved width or halved height would be zero, even if `levels` asks for more.
- R10: A start while pairs are being emitted is ignored. The input values present then do not change the running sequence.
- R11: After reset, `out_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a job; captured only while idle |
| in_width | input | 13 | Image width in pixels |
| in_height | input | 13 | Image height in pixels |
| in_pitch | input | 16 | Source row pitch in bytes for level 0 |
| in_bpp | input | 4 | Bytes per pixel |
| in_levels | input | 4 | Number of mipmap levels to walk |
| in_src_base | input | 32 | Linear source base address |
| in_dst_base | input | 32 | Swizzled destination base address |
| out_valid | output | 1 | Address pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_src_addr | output | 32 | Linear source address of the sub-tile |
| out_dst_addr | output | 32 | Swizzled destination address of the sub-tile |
| out_tile_w | output | 13 | Sub-tile width |
| out_tile_h | output | 13 | Sub-tile height |
| out_log2_w | output | 4 | log2 of level width |
| out_log2_h | output | 4 | log2 of level height |
| out_level | output | 4 | Current mipmap level index |
| done | output | 1 | One-cycle pulse at the end of a job |
| err | output | 1 | One-cycle pulse for a rejected size |

## Verification
The bench targets these corner cases, each with the wrong behaviour it would expose:
- **4096-pixel images.** These span four sub-tiles per axis. A walker that swapped loop order or mis-sized tiles would emit addresses in the wrong sequence.
- **Long chains and narrow images.** Full-depth chains run down to 1x1, and narrow images run out of height early. A design that skipped the early end would emit zero-size levels or pulse done late.
- **Rejected sizes.** Non-power-of-two and zero sizes are fed in. A size check that accepted them would produce pairs instead of an error pulse.
- **Stalls and extra starts.** Random ready stalls are mixed with a start during a busy job. Addresses that drift under back-pressure, or a walker reloaded by that start, would show up as mismatched pairs.

// File: rtl/morton_pkg.sv
package morton_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } walk_state_t;

  function automatic logic is_pow2(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  function automatic logic [5:0] log2_of(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/morton_interleave.sv
module morton_interleave #(
  parameter int CW = 12
) (
  input  logic [CW-1:0]   x,
  input  logic [CW-1:0]   y,
  output logic [2*CW-1:0] idx
);
  for (genvar b = 0; b < CW; b++) begin : g_bit
    assign idx[2*b]   = x[b];
    assign idx[2*b+1] = y[b];
  end
endmodule

// File: rtl/morton_tile_walk.sv
module morton_tile_walk #(
  parameter int CW        = 12,
  parameter int TILE_LOG2 = 10,
  localparam int SIZE_W   = CW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [SIZE_W-1:0] w,
  input  logic [SIZE_W-1:0] h,
  output logic [CW-1:0]     cx,
  output logic [CW-1:0]     cy,
  output logic [SIZE_W-1:0] tile_w,
  output logic [SIZE_W-1:0] tile_h,
  output logic              last_tile
);
  localparam logic [SIZE_W-1:0] TILE = SIZE_W'(1) << TILE_LOG2;

  logic x_end, y_end;

  assign tile_w    = (w > TILE) ? TILE : w;
  assign tile_h    = (h > TILE) ? TILE : h;
  assign x_end     = (SIZE_W'(cx) + tile_w) >= w;
  assign y_end     = (SIZE_W'(cy) + tile_h) >= h;
  assign last_tile = x_end && y_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx <= '0;
      cy <= '0;
    end else if (clear) begin
      cx <= '0;
      cy <= '0;
    end else if (step) begin
      if (x_end) begin
        cx <= '0;
        cy <= y_end ? '0 : cy + CW'(tile_h);
      end else begin
        cx <= cx + CW'(tile_w);
      end
    end
  end
endmodule

// File: rtl/morton_level_state.sv
module morton_level_state #(
  parameter int SIZE_W  = 13,
  parameter int PITCH_W = 16,
  parameter int ADDR_W  = 32,
  parameter int BPP_W   = 4,
  parameter int LVL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [SIZE_W-1:0]  in_w,
  input  logic [SIZE_W-1:0]  in_h,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic [BPP_W-1:0]   in_bpp,
  input  logic [LVL_W-1:0]   in_levels,
  input  logic [ADDR_W-1:0]  in_sbase,
  input  logic [ADDR_W-1:0]  in_dbase,
  output logic [SIZE_W-1:0]  w,
  output logic [SIZE_W-1:0]  h,
  output logic [PITCH_W-1:0] pitch,
  output logic [BPP_W-1:0]   bpp,
  output logic [ADDR_W-1:0]  soff,
  output logic [ADDR_W-1:0]  doff,
  output logic [LVL_W-1:0]   level,
  output logic               last_level
);
  logic [LVL_W-1:0]  levels_q;
  logic [ADDR_W-1:0] level_bytes;

  assign level_bytes = ADDR_W'(w) * ADDR_W'(h) * ADDR_W'(bpp);
  assign last_level  = (level == levels_q - LVL_W'(1)) ||
                       (w[SIZE_W-1:1] == '0) || (h[SIZE_W-1:1] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w        <= '0;
      h        <= '0;
      pitch    <= '0;
      bpp      <= '0;
      soff     <= '0;
      doff     <= '0;
      level    <= '0;
      levels_q <= '0;
    end else if (load) begin
      w        <= in_w;
      h        <= in_h;
      pitch    <= in_pitch;
      bpp      <= in_bpp;
      soff     <= in_sbase;
      doff     <= in_dbase;
      level    <= '0;
      levels_q <= in_levels;
    end else if (step) begin
      soff  <= soff + level_bytes;
      doff  <= doff + level_bytes;
      w     <= w >> 1;
      h     <= h >> 1;
      pitch <= pitch >> 1;
      level <= level + LVL_W'(1);
    end
  end
endmodule

// File: rtl/morton_addr_gen.sv
module morton_addr_gen #(
  parameter int CW        = 12,
  parameter int TILE_LOG2 = 10,
  parameter int PITCH_W   = 16,
  parameter int ADDR_W    = 32,
  parameter int BPP_W     = 4,
  parameter int LVL_W     = 4,
  localparam int SIZE_W   = CW + 1,
  localparam int LOG_W    = $clog2(SIZE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SIZE_W-1:0]  in_width,
  input  logic [SIZE_W-1:0]  in_height,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic [BPP_W-1:0]   in_bpp,
  input  logic [LVL_W-1:0]   in_levels,
  input  logic [ADDR_W-1:0]  in_src_base,
  input  logic [ADDR_W-1:0]  in_dst_base,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_src_addr,
  output logic [ADDR_W-1:0]  out_dst_addr,
  output logic [SIZE_W-1:0]  out_tile_w,
  output logic [SIZE_W-1:0]  out_tile_h,
  output logic [LOG_W-1:0]   out_log2_w,
  output logic [LOG_W-1:0]   out_log2_h,
  output logic [LVL_W-1:0]   out_level,
  output logic               done,
  output logic               err
);
  import morton_pkg::*;

  walk_state_t state;

  logic               accept, size_ok, load, fire;
  logic               level_step, chain_end, last_tile, last_level;
  logic [CW-1:0]      cx, cy;
  logic [2*CW-1:0]    zidx;
  logic [SIZE_W-1:0]  lw, lh;
  logic [PITCH_W-1:0] lpitch;
  logic [BPP_W-1:0]   lbpp;
  logic [ADDR_W-1:0]  soff, doff;

  assign size_ok    = is_pow2(32'(in_width)) && is_pow2(32'(in_height));
  assign accept     = start && (state == ST_IDLE);
  assign load       = accept && size_ok && (in_levels != '0);
  assign out_valid  = (state == ST_EMIT);
  assign fire       = out_valid && out_ready;
  assign level_step = fire && last_tile;
  assign chain_end  = level_step && last_level;

  morton_level_state #(
    .SIZE_W(SIZE_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W),
    .BPP_W(BPP_W), .LVL_W(LVL_W)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .load(load), .step(level_step),
    .in_w(in_width), .in_h(in_height), .in_pitch(in_pitch),
    .in_bpp(in_bpp), .in_levels(in_levels),
    .in_sbase(in_src_base), .in_dbase(in_dst_base),
    .w(lw), .h(lh), .pitch(lpitch), .bpp(lbpp),
    .soff(soff), .doff(doff), .level(out_level), .last_level(last_level)
  );

  morton_tile_walk #(.CW(CW), .TILE_LOG2(TILE_LOG2)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(load || level_step), .step(fire),
    .w(lw), .h(lh), .cx(cx), .cy(cy),
    .tile_w(out_tile_w), .tile_h(out_tile_h), .last_tile(last_tile)
  );

  morton_interleave #(.CW(CW)) u_zorder (.x(cx), .y(cy), .idx(zidx));

  assign out_dst_addr = doff + ADDR_W'(zidx) * ADDR_W'(lbpp);
  assign out_src_addr = soff + ADDR_W'(cy) * ADDR_W'(lpitch)
                             + ADDR_W'(cx) * ADDR_W'(lbpp);
  assign out_log2_w   = LOG_W'(log2_of(32'(lw)));
  assign out_log2_h   = LOG_W'(log2_of(32'(lh)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= chain_end || (accept && size_ok && (in_levels == '0));
      err  <= accept && !size_ok;
      if (load) state <= ST_EMIT;
      else if (chain_end) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/morton_addr_gen_checker.sv
module morton_addr_gen_checker #(
  parameter int SIZE_W    = 13,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int TILE_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_src_addr,
  input logic [ADDR_W-1:0] out_dst_addr,
  input logic [SIZE_W-1:0] out_tile_w,
  input logic [SIZE_W-1:0] out_tile_h,
  input logic [LVL_W-1:0]  out_level,
  input logic              done,
  input logic              err,
  input logic              level_step
);
  localparam logic [SIZE_W-1:0] TILE = SIZE_W'(1) << TILE_LOG2;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src_addr) &&
                                   $stable(out_dst_addr) && $stable(out_level)));

  p_tile_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_tile_w) == 1 && out_tile_w <= TILE &&
                   $countones(out_tile_h) == 1 && out_tile_h <= TILE));

  p_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level_step |=> (out_level == $past(out_level) + LVL_W'(1)));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !out_valid));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

bind morton_addr_gen morton_addr_gen_checker #(
  .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .TILE_LOG2(TILE_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_src_addr(out_src_addr), .out_dst_addr(out_dst_addr),
  .out_tile_w(out_tile_w), .out_tile_h(out_tile_h), .out_level(out_level),
  .done(done), .err(err), .level_step(level_step)
);

// File: tb/morton_addr_gen_bench.sv
module morton_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] in_width = '0, in_height = '0;
  logic [15:0] in_pitch = '0;
  logic [3:0]  in_bpp = '0, in_levels = '0;
  logic [31:0] in_src_base = '0, in_dst_base = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, done, err;
  logic [31:0] out_src_addr, out_dst_addr;
  logic [12:0] out_tile_w, out_tile_h;
  logic [3:0]  out_log2_w, out_log2_h, out_level;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  morton_addr_gen u_morton_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_width(in_width), .in_height(in_height), .in_pitch(in_pitch),
    .in_bpp(in_bpp), .in_levels(in_levels),
    .in_src_base(in_src_base), .in_dst_base(in_dst_base),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src_addr(out_src_addr), .out_dst_addr(out_dst_addr),
    .out_tile_w(out_tile_w), .out_tile_h(out_tile_h),
    .out_log2_w(out_log2_w), .out_log2_h(out_log2_h),
    .out_level(out_level), .done(done), .err(err)
  );

  function automatic logic [31:0] zorder(input int x, input int y);
    logic [31:0] r = 0;
    for (int b = 11; b >= 0; b--) begin
      r = (r << 2) | 32'(((y >> b) & 1) << 1) | 32'((x >> b) & 1);
    end
    return r;
  endfunction

  function automatic bit pow2(input int v);
    int n = 0;
    for (int b = 0; b < 31; b++) if ((v >> b) & 1) n++;
    return n == 1;
  endfunction

  function automatic int ilog2(input int v);
    int r = 0;
    while ((1 << (r + 1)) <= v) r++;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_pair(input logic [31:0] es, input logic [31:0] ed,
                             input int tw, input int th, input int lw,
                             input int lh, input int lv, input int pct,
                             inout bit poke);
    int tries = 0;
    bit stalled = 0;
    forever begin
      bit go;
      go = (($urandom % 100) < pct) || (tries >= 6);
      if (poke) go = 0;
      chk(out_valid == 1'b1, stalled ? "R7 valid held" : "R3 valid", 32'(out_valid), 1);
      chk(out_dst_addr == ed, stalled ? "R7 dst held" : "R1 dst", out_dst_addr, ed);
      chk(out_src_addr == es, "R2 src", out_src_addr, es);
      chk(out_tile_w == 13'(tw) && out_tile_h == 13'(th), "R3 tile size",
          {out_tile_w, 3'b0, out_tile_h}, 32'((tw << 16) | th));
      chk(out_level == 4'(lv), "R4 level", 32'(out_level), 32'(lv));
      chk(out_log2_w == 4'(ilog2(lw)) && out_log2_h == 4'(ilog2(lh)), "R5 log2",
          32'({out_log2_w, out_log2_h}), 32'((ilog2(lw) << 4) | ilog2(lh)));
      out_ready = go;
      if (poke) begin
        start = 1'b1;
        in_width = 13'd16; in_height = 13'd16; in_bpp = 4'd7;
        in_levels = 4'd2; in_src_base = 32'h5555_0000; in_dst_base = 32'h0;
        in_pitch = 16'd3;
      end
      @(negedge clk);
      start = 1'b0;
      poke = 0;
      out_ready = 1'b0;
      tries++;
      if (go) return;
      stalled = 1;
    end
  endtask

  task automatic run_job(input int w, input int h, input int pitch, input int bpp,
                         input int lv, input logic [31:0] sb, input logic [31:0] db,
                         input int pct, input bit poke_busy, input string dtag);
    int cw = w, ch = h, cp = pitch;
    logic [31:0] so = sb, dof = db;
    bit poke = poke_busy;
    in_width = 13'(w); in_height = 13'(h); in_pitch = 16'(pitch);
    in_bpp = 4'(bpp); in_levels = 4'(lv); in_src_base = sb; in_dst_base = db;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!(pow2(w) && pow2(h))) begin
      chk(err == 1'b1 && out_valid == 1'b0, "R6 err pulse", 32'({err, out_valid}), 2);
      @(negedge clk);
      chk(err == 1'b0 && done == 1'b0 && out_valid == 1'b0, "R6 one cycle, no output",
          32'({err, done, out_valid}), 0);
      return;
    end
    if (lv == 0) begin
      chk(done == 1'b1 && out_valid == 1'b0, "R8 zero levels", 32'({done, out_valid}), 2);
      @(negedge clk);
      return;
    end
    for (int l = 0; l < lv; l++) begin
      int tw, th;
      if (cw == 0 || ch == 0) break;
      tw = (cw > 1024) ? 1024 : cw;
      th = (ch > 1024) ? 1024 : ch;
      for (int y = 0; y < ch; y += th) begin
        for (int x = 0; x < cw; x += tw) begin
          logic [31:0] es, ed;
          es = so + 32'(y) * 32'(cp) + 32'(x) * 32'(bpp);
          ed = dof + zorder(x, y) * 32'(bpp);
          expect_pair(es, ed, tw, th, cw, ch, l, pct, poke);
        end
      end
      so = so + 32'(cw) * 32'(ch) * 32'(bpp);
      dof = dof + 32'(cw) * 32'(ch) * 32'(bpp);
      cw = cw >> 1; ch = ch >> 1; cp = cp >> 1;
    end
    chk(done == 1'b1 && out_valid == 1'b0, dtag, 32'({done, out_valid}), 2);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && done == 0 && err == 0, "R11 reset", 32'({out_valid, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && done == 0 && err == 0, "R11 after release",
        32'({out_valid, done, err}), 0);

    run_job(4096, 4096, 16384, 4, 13, 32'h1000_0000, 32'h2000_0000, 70, 0, "R9 full chain done");
    run_job(2048, 8, 4096, 2, 9, 32'h0000_0040, 32'h0008_0000, 100, 0, "R9 early end done");
    run_job(2048, 1024, 8192, 4, 1, 32'h0, 32'h0, 50, 0, "R3 two tiles done");
    run_job(1024, 1024, 2048, 2, 1, 32'hFFFF_F000, 32'h0, 100, 0, "R2 single tile done");
    run_job(3, 4, 12, 4, 2, 32'h0, 32'h0, 100, 0, "R6");
    run_job(0, 8, 12, 4, 2, 32'h0, 32'h0, 100, 0, "R6");
    run_job(64, 48, 256, 4, 2, 32'h0, 32'h0, 100, 0, "R6");
    run_job(64, 64, 256, 4, 0, 32'h0, 32'h0, 100, 0, "R8");
    run_job(4096, 256, 8192, 1, 3, 32'h0300_0000, 32'h0400_0000, 60, 1, "R10 busy start ignored");

    for (int j = 0; j < 40; j++) begin
      int w, h;
      w = 1 << ($urandom % 13);
      h = 1 << ($urandom % 13);
      if (j % 9 == 4) w = w + 3;
      run_job(w, h, int'($urandom % 65536), 1 + int'($urandom % 8),
              int'($urandom % 14), $urandom, $urandom, 40 + int'($urandom % 61),
              (j % 7) == 2, "R8 random done");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule